// File: doc/BRIEF.md
# Serial Transmitter with Address/Data Marker Bit

This block sends bytes over a single asynchronous serial line. Each frame carries one extra marker bit after the data bits. A marker of 1 flags the frame as an address (ID) frame, and a marker of 0 flags it as a plain data frame. Receivers on a shared line use the marker to tell which frames are meant for them. Bit timing comes from an external baud tick. Every bit lasts `OVERSAMPLE` ticks.

Software drives the block through a small write port with four addresses:

- **Data (address 0):** holds the next byte.
- **Status (address 1):** bit 0 is the empty flag, which software clears by writing 0; bit 1 is the marker control.
- **Control (address 2):** bit 0 is the transmit enable.
- **Port (address 3):** bit 0 is the pin level and bit 1 is the pin direction. This register owns the pin while the transmitter is disabled.

Writing 0 to status bit 0 while the empty flag is set commits the byte in the data register. When the byte moves into the shifter, the empty flag rises again, so the next byte can be queued while the current frame is still being sent. Each time the transmitter is enabled, it first sends one frame-length stretch of ones. Disabling the transmitter stops any frame at once and gives the pin to the port register, which can hold a break (constant low).

The sequencer has seven states:

- `ST_OFF`: disabled.
- `ST_WAKE`: the idle frame of ones.
- `ST_IDLE`: line high, waiting for data.
- `ST_START`, `ST_DATA`, `ST_MARK`, `ST_STOP`: the parts of a frame.

Its transitions are:

- **enable:** OFF to WAKE.
- **wake done:** WAKE to IDLE, or WAKE to START when a byte is pending.
- **launch:** IDLE to START when a byte is pending.
- **start done:** START to DATA.
- **last data bit:** DATA to MARK.
- **marker done:** MARK to STOP.
- **chain:** STOP to START when a byte is pending.
- **finish:** STOP to IDLE when nothing is pending.
- **disable:** from any state to OFF.

Top module: `mpu_frame_tx`

## Requirements
- R1: After reset the line is high, the empty flag and the end flag are 1, the marker control reads 0 and the transmitter is disabled.
- R2: When control bit 0 goes from 0 to 1, the line stays high for (DATA_W+3)·OVERSAMPLE baud ticks before any frame starts.
- R3: A frame is a start bit of 0, then DATA_W data bits with the least significant first, then the marker bit, then a stop bit of 1. Each bit lasts OVERSAMPLE baud ticks.
- R4: The marker bit sent in a frame equals status bit 1 in the write that committed that byte. Later writes to status bit 1 do not change a frame that is already pending.
- R5: A status write (address 1) with bit 0 = 0 while the empty flag is 1 commits the byte and clears both the empty and end flags. A status write with bit 0 = 1, or one made while the empty flag is 0, commits nothing. Every status write updates the marker control output to its bit 1.
- R6: The empty flag returns to 1 when a committed byte enters the shifter. A byte committed before the current stop bit ends is sent immediately after it, with no idle gap.
- R7: The end flag becomes 1 when a stop bit ends with no byte pending. The line then idles high.
- R8: While disabled, the line is the port level (address 3 bit 0) if the port direction (address 3 bit 1) is 1, and high otherwise. This lets software hold a break (low).
- R9: Writing control bit 0 = 0 while enabled aborts the frame at once and sets the empty and end flags. The next enable starts again with the idle frame of R2.
- R10: The data register (address 0) can be rewritten while a frame is shifting without altering that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse per oversample period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 data, 1 status, 2 control, 3 port) |
| wr_data | input | DATA_W | Register write value |
| txd | output | 1 | Serial line |
| stat_empty | output | 1 | Data register empty flag |
| stat_end | output | 1 | Transmission end flag |
| stat_mark | output | 1 | Marker control bit |

## Verification
The bench builds the block with DATA_W = 8 and OVERSAMPLE = 4, with a baud tick every third clock. A whole frame therefore takes about 130 cycles. This short bit time makes several scenarios reachable in a short run: the idle frame after each enable, chained frames whose marker changes from 1 to 0, an abort in the middle of a frame followed by a break, and a restart. A behavioural model built on a bit queue predicts the line and the three flags on every clock. Each mismatch is tagged with the requirement for the part of the frame it falls in.

// File: rtl/mputx_pkg.sv
package mputx_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAKE,
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_MARK,
        ST_STOP
    } tx_state_t;

    localparam logic [1:0] ADR_DATA = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_CTRL = 2'd2;
    localparam logic [1:0] ADR_PORT = 2'd3;

endpackage

// File: rtl/mputx_baud_div.sv
module mputx_baud_div #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic baud_tick,
    output logic bit_end
);
    localparam int CW = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (baud_tick) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign bit_end = baud_tick && (cnt == LAST);

endmodule

// File: rtl/mputx_regs.sv
module mputx_regs
    import mputx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load,
    input  logic              finish,
    output logic              en,
    output logic [DATA_W-1:0] tdr,
    output logic              pend_mark,
    output logic              empty,
    output logic              done,
    output logic              mark_ctl,
    output logic              port_dir,
    output logic              port_lvl
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en        <= 1'b0;
            tdr       <= '0;
            pend_mark <= 1'b0;
            empty     <= 1'b1;
            done      <= 1'b1;
            mark_ctl  <= 1'b0;
            port_dir  <= 1'b0;
            port_lvl  <= 1'b0;
        end else begin
            if (load)   empty <= 1'b1;
            if (finish) done  <= 1'b1;
            if (wr_en) begin
                case (wr_addr)
                    ADR_DATA: tdr <= wr_data;
                    ADR_STAT: begin
                        mark_ctl <= wr_data[1];
                        if (!wr_data[0] && empty) begin
                            empty     <= 1'b0;
                            done      <= 1'b0;
                            pend_mark <= wr_data[1];
                        end
                    end
                    ADR_CTRL: begin
                        en <= wr_data[0];
                        if (en && !wr_data[0]) begin
                            empty <= 1'b1;
                            done  <= 1'b1;
                        end
                    end
                    default: begin
                        port_lvl <= wr_data[0];
                        port_dir <= wr_data[1];
                    end
                endcase
            end
        end
    end

    // R6: a hand-off to the shifter leaves the data register free
    a_r6_empty_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> empty);

    // R5: a commit clears both flags
    a_r5_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_STAT && !wr_data[0] && empty) |=> (!empty && !done));

endmodule

// File: rtl/mputx_fsm.sv
module mputx_fsm
    import mputx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              empty,
    input  logic              bit_end,
    input  logic [DATA_W-1:0] tdr,
    input  logic              pend_mark,
    output logic              load,
    output logic              finish,
    output logic              restart,
    output logic              line,
    output tx_state_t         st
);
    localparam int FRAME_BITS = DATA_W + 3;
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] LAST_FRAME = IW'(FRAME_BITS - 1);
    localparam logic [IW-1:0] LAST_DATA  = IW'(DATA_W - 1);

    tx_state_t         nxt;
    logic [DATA_W-1:0] shreg;
    logic              mark_q;
    logic [IW-1:0]     idx;
    logic              idx_clr, idx_inc, shift;

    // next state and transition strobes
    always_comb begin
        nxt     = st;
        load    = 1'b0;
        finish  = 1'b0;
        idx_clr = 1'b0;
        idx_inc = 1'b0;
        shift   = 1'b0;
        if (!en) begin
            nxt = ST_OFF;
        end else begin
            unique case (st)
                ST_OFF: begin
                    nxt     = ST_WAKE;
                    idx_clr = 1'b1;
                end
                ST_WAKE: if (bit_end) begin
                    if (idx == LAST_FRAME) begin
                        if (!empty) begin
                            nxt  = ST_START;
                            load = 1'b1;
                        end else begin
                            nxt = ST_IDLE;
                        end
                    end else begin
                        idx_inc = 1'b1;
                    end
                end
                ST_IDLE: if (!empty) begin
                    nxt  = ST_START;
                    load = 1'b1;
                end
                ST_START: if (bit_end) begin
                    nxt     = ST_DATA;
                    idx_clr = 1'b1;
                end
                ST_DATA: if (bit_end) begin
                    shift = 1'b1;
                    if (idx == LAST_DATA) nxt = ST_MARK;
                    else                  idx_inc = 1'b1;
                end
                ST_MARK: if (bit_end) nxt = ST_STOP;
                ST_STOP: if (bit_end) begin
                    if (!empty) begin
                        nxt  = ST_START;
                        load = 1'b1;
                    end else begin
                        nxt    = ST_IDLE;
                        finish = 1'b1;
                    end
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_OFF;
            shreg  <= '0;
            mark_q <= 1'b0;
            idx    <= '0;
        end else begin
            st <= nxt;
            if (load) begin
                shreg  <= tdr;
                mark_q <= pend_mark;
            end else if (shift) begin
                shreg <= shreg >> 1;
            end
            if (idx_clr)      idx <= '0;
            else if (idx_inc) idx <= idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        restart = 1'b0;
        line    = 1'b1;
        unique case (st)
            ST_OFF:   restart = 1'b1;
            ST_IDLE:  restart = 1'b1;
            ST_WAKE:  line = 1'b1;
            ST_START: line = 1'b0;
            ST_DATA:  line = shreg[0];
            ST_MARK:  line = mark_q;
            ST_STOP:  line = 1'b1;
            default:  line = 1'b1;
        endcase
    end

    // R9: a disabled transmitter falls back to OFF on the next edge
    a_r9_off_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st == ST_OFF));

endmodule

// File: rtl/mpu_frame_tx.sv
module mpu_frame_tx
    import mputx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              stat_empty,
    output logic              stat_end,
    output logic              stat_mark
);
    logic              en, pend_mark, empty, done, mark_ctl, port_dir, port_lvl;
    logic [DATA_W-1:0] tdr;
    logic              load, finish, restart, line, bit_end;
    tx_state_t         st;

    mputx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load(load), .finish(finish), .en(en), .tdr(tdr), .pend_mark(pend_mark),
        .empty(empty), .done(done), .mark_ctl(mark_ctl),
        .port_dir(port_dir), .port_lvl(port_lvl)
    );

    mputx_baud_div #(.OVERSAMPLE(OVERSAMPLE)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(restart), .baud_tick(baud_tick), .bit_end(bit_end)
    );

    mputx_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .empty(empty), .bit_end(bit_end),
        .tdr(tdr), .pend_mark(pend_mark), .load(load), .finish(finish),
        .restart(restart), .line(line), .st(st)
    );

    assign txd        = en ? line : (port_dir ? port_lvl : 1'b1);
    assign stat_empty = empty;
    assign stat_end   = done;
    assign stat_mark  = mark_ctl;

    // R2: the idle frame keeps the line high
    a_r2_wake_high: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st == ST_WAKE) |-> txd);

    // R3: the shifter takes a byte only when one is committed
    a_r3_load_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !empty);

    // R7: end flag with the transmitter enabled means no frame is on the line
    a_r7_end_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en && done) |-> (st == ST_OFF || st == ST_WAKE || st == ST_IDLE));

endmodule

// File: tb/mpu_frame_tx_test.sv
module mpu_frame_tx_test;
    localparam int DW = 8;
    localparam int OS = 4;
    localparam int FB = DW + 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          baud_tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic          txd, stat_empty, stat_end, stat_mark;

    int checks = 0;
    int fails  = 0;
    int tdiv   = 0;

    mpu_frame_tx #(.DATA_W(DW), .OVERSAMPLE(OS)) uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .txd(txd),
        .stat_empty(stat_empty), .stat_end(stat_end), .stat_mark(stat_mark)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        tdiv      = (tdiv == 2) ? 0 : tdiv + 1;
        baud_tick = (tdiv == 2);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model
    bit            m_en, m_empty, m_done, m_mark, m_pmark, m_pdir, m_plvl, m_off;
    logic [DW-1:0] m_tdr;
    bit            m_q[$];
    int            m_tick, m_kind;

    function automatic void push_frame();
        m_q.delete();
        m_q.push_back(1'b0);
        for (int i = 0; i < DW; i++) m_q.push_back(m_tdr[i]);
        m_q.push_back(m_pmark);
        m_q.push_back(1'b1);
        m_kind = 2;
    endfunction

    always @(posedge clk) begin
        bit o_en, o_empty, n_empty, n_done;
        if (!rst_n) begin
            m_en = 0; m_empty = 1; m_done = 1; m_mark = 0; m_pmark = 0;
            m_pdir = 0; m_plvl = 0; m_off = 1; m_tdr = '0; m_tick = 0; m_kind = 0;
            m_q.delete();
        end else begin
            o_en = m_en; o_empty = m_empty; n_empty = m_empty; n_done = m_done;
            if (!o_en) begin
                m_q.delete(); m_off = 1; m_tick = 0; m_kind = 0;
            end else if (m_off) begin
                m_off = 0; m_q.delete();
                repeat (FB) m_q.push_back(1'b1);
                m_tick = 0; m_kind = 1;
            end else if (m_q.size() == 0) begin
                m_tick = 0;
                if (!o_empty) begin push_frame(); n_empty = 1; end
            end else if (baud_tick) begin
                if (m_tick == OS - 1) begin
                    m_tick = 0;
                    void'(m_q.pop_front());
                    if (m_q.size() == 0) begin
                        if (!o_empty) begin push_frame(); n_empty = 1; end
                        else begin n_done = 1; m_kind = 0; end
                    end
                end else begin
                    m_tick++;
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_tdr = wr_data;
                    2'd1: begin
                        m_mark = wr_data[1];
                        if (!wr_data[0] && o_empty) begin
                            n_empty = 0; n_done = 0; m_pmark = wr_data[1];
                        end
                    end
                    2'd2: begin
                        if (o_en && !wr_data[0]) begin n_empty = 1; n_done = 1; end
                        m_en = wr_data[0];
                    end
                    default: begin m_plvl = wr_data[0]; m_pdir = wr_data[1]; end
                endcase
            end
            m_empty = n_empty; m_done = n_done;
        end
    end

    always @(negedge clk) begin
        bit    exp_tx;
        string tag;
        if (rst_n) begin
            if (!m_en) begin
                exp_tx = m_pdir ? m_plvl : 1'b1; tag = "R8";
            end else if (m_q.size() > 0) begin
                exp_tx = m_q[0];
                if (m_kind == 1)          tag = "R2";
                else if (m_q.size() == 2) tag = "R4";
                else                      tag = "R3";
            end else begin
                exp_tx = 1'b1; tag = "R7";
            end
            check(txd == exp_tx, {tag, " line"}, txd, exp_tx);
            check(stat_empty == m_empty, "R6 empty flag", stat_empty, m_empty);
            check(stat_end == m_done, "R7 end flag", stat_end, m_done);
            check(stat_mark == m_mark, "R5 marker control", stat_mark, m_mark);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_end();
        while (!stat_end) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 line", txd, 1);
        check(stat_empty == 1'b1, "R1 empty", stat_empty, 1);
        check(stat_end == 1'b1, "R1 end", stat_end, 1);
        check(stat_mark == 1'b0, "R1 mark", stat_mark, 0);

        // R8 port owns the pin while disabled
        wr(2'd3, 8'h02);
        check(txd == 1'b0, "R8 break low", txd, 0);
        wr(2'd3, 8'h03);
        check(txd == 1'b1, "R8 port level high", txd, 1);
        wr(2'd3, 8'h00);
        check(txd == 1'b1, "R8 released pin", txd, 1);

        // enable, commit an ID frame
        wr(2'd2, 8'h01);
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h02);
        check(stat_empty == 1'b0, "R5 commit clears empty", stat_empty, 0);
        check(stat_end == 1'b0, "R5 commit clears end", stat_end, 0);
        check(txd == 1'b1, "R2 idle frame high", txd, 1);

        while (!stat_empty) @(negedge clk);
        check(txd == 1'b0, "R3 start bit after hand-off", txd, 0);
        // R10 rewrite data during the frame, then chain a data frame
        wr(2'd0, 8'h3C);
        wr(2'd1, 8'h00);
        wr(2'd1, 8'h03);
        check(stat_mark == 1'b1, "R4 control changed after commit", stat_mark, 1);
        check(stat_empty == 1'b0, "R5 no commit when bit0 is 1", stat_empty, 0);
        wait_end();
        check(txd == 1'b1, "R7 line idles high", txd, 1);
        wr(2'd1, 8'h01);
        check(stat_empty == 1'b1, "R5 bit0=1 leaves empty", stat_empty, 1);
        check(stat_end == 1'b1, "R5 bit0=1 leaves end", stat_end, 1);

        // R9 abort in mid-frame, break, restart
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h00);
        repeat (40) @(negedge clk);
        wr(2'd2, 8'h00);
        check(stat_empty == 1'b1, "R9 abort sets empty", stat_empty, 1);
        check(stat_end == 1'b1, "R9 abort sets end", stat_end, 1);
        check(txd == 1'b1, "R9 pin released", txd, 1);
        wr(2'd3, 8'h02);
        repeat (20) @(negedge clk);
        check(txd == 1'b0, "R8 break held", txd, 0);
        wr(2'd3, 8'h00);
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wait_end();
        check(txd == 1'b1, "R9 restart completes", txd, 1);
        repeat (10) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule